// File: doc/BRIEF.md
# Process-Tagged Translation Buffer with Recency Replacement

This block is a small fully associative buffer that turns a virtual page number into a physical frame number. Every resident entry carries the identifier of the address space it belongs to. Translations from several processes can therefore share the buffer, and a process switch does not force it to be emptied. A lookup presents a page number together with the identifier of the running process. In the same cycle, without a clock edge, the block answers with a hit flag, the frame number and a write-permission bit.

When a lookup misses, logic outside this block finds the translation and writes it back through the fill port. A fill goes first to a free slot, taking the lowest-numbered one. When no slot is free, it replaces the entry that has gone unused the longest. A fill for a page and identifier that are already resident rewrites that entry in place. Two commands remove entries: one drops a single page of one address space, the other clears the whole buffer.

Top module: `asid_tlb`

## Requirements
- R1: A lookup (lk_req high) reports lk_hit high in the same cycle only if a valid entry holds both lk_vpn and lk_asid; it then returns that entry's frame on lk_pfn and its write bit on lk_wr_ok. lk_hit is never high without lk_req.
- R2: A lookup whose page number matches a resident entry but whose identifier differs gets lk_hit low, the same answer as any other miss; the block has no fault output.
- R3: After a fill, a lookup of the same page and identifier in the next cycle or later hits and returns the filled frame and write bit.
- R4: While any entry is invalid, a fill never removes a valid entry.
- R5: When all entries are valid, a fill of a new translation replaces the least recently used entry. A hit in a cycle with no command, and every fill, mark the entry as most recently used.
- R6: A fill whose page and identifier are already resident overwrites that entry, so no page and identifier pair is ever held twice and no other entry is lost.
- R7: An invalidate (inv_en) removes only the entry matching both inv_vpn and inv_asid; the same page under another identifier stays resident.
- R8: flush_en removes every entry, so every following lookup misses until new fills arrive.
- R9: Entries of an identifier that is not current stay resident, and they hit again once that identifier is presented on lookups.
- R10: When commands coincide, flush wins over invalidate and invalidate wins over fill; the losing command is dropped. A lookup sees the contents from before the commands of its own cycle.
- R11: After reset every entry is invalid and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_asid | input | 8 | Identifier of the running process |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 20 | Frame number on a hit, zero otherwise |
| lk_wr_ok | output | 1 | Write permission on a hit, zero otherwise |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Page number to install |
| fill_asid | input | 8 | Identifier to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_wr | input | 1 | Write permission to install |
| inv_en | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Page number to invalidate |
| inv_asid | input | 8 | Identifier of the page to invalidate |
| flush_en | input | 1 | Invalidate all entries |

## Verification
The properties assume that a fill and a lookup of the same page in the cycle after it describe the same address space. They also assume that the recency state is only disturbed by fills and by hits in cycles with no command. The stimulus mostly issues lookups and commands in separate cycles, so each result follows from a single ordering. Deliberate collisions of flush, invalidate, fill and lookup are confined to the cases that test R10. Page numbers and identifiers are picked so that pages shared between two identifiers test the identifier comparison and nothing else.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // where a fill writes
  typedef enum logic [1:0] {
    WAY_SAME = 2'd0,  // rewrite the resident copy
    WAY_FREE = 2'd1,  // lowest invalid slot
    WAY_LRU  = 2'd2   // oldest valid slot
  } fill_src_e;
endpackage

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]      valid,
  input  logic [VPN_W-1:0]  vpn_tab  [N],
  input  logic [ASID_W-1:0] asid_tab [N],
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic [N-1:0]      match
);
  function automatic logic tag_eq(input logic [VPN_W-1:0] a_vpn, input logic [ASID_W-1:0] a_id,
                                  input logic [VPN_W-1:0] b_vpn, input logic [ASID_W-1:0] b_id);
    return (a_vpn == b_vpn) && (a_id == b_id);
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && tag_eq(vpn_tab[g], asid_tab[g], key_vpn, key_asid);
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  localparam logic [IW-1:0] AGE_MAX = IW'(N - 1);

  logic [IW-1:0] age_q [N];
  logic [N-1:0]  oldest_vec;
  logic          victim_any;

  // age after entry `who` is touched, given the touched entry's old age
  function automatic logic [IW-1:0] aged(input logic [IW-1:0] cur, input logic [IW-1:0] ref_age,
                                         input logic is_touched);
    if (is_touched)      return '0;
    if (cur < ref_age)   return cur + 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++)
        age_q[i] <= aged(age_q[i], age_q[touch_idx], touch_idx == IW'(i));
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest_vec[g] = (age_q[g] == AGE_MAX);
  end

  tlb_pick #(.N(N), .IW(IW)) u_old (.vec(oldest_vec), .any(victim_any), .idx(victim_idx));

  // ages stay a permutation: exactly one oldest entry
  assert_one_oldest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest_vec) && victim_any);
  // a touched entry is never the next victim
  assert_touch_young_R5: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> !oldest_vec[$past(touch_idx)]);
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic              lk_wr_ok,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_wr,
  input  logic              inv_en,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic              flush_en
);
  import tlb_pkg::*;
  localparam int IW = $clog2(N);

  logic [N-1:0]      valid_q;
  logic [VPN_W-1:0]  vpn_q  [N];
  logic [ASID_W-1:0] asid_q [N];
  logic [PFN_W-1:0]  pfn_q  [N];
  logic [N-1:0]      wr_q;

  logic [N-1:0]  lk_match, fill_match, inv_match;
  logic          lk_any, same_any, free_any;
  logic [IW-1:0] lk_idx, same_idx, free_idx, lru_idx, way;
  fill_src_e     src;

  // named internal events
  logic do_flush, do_inv, do_fill, touch_en;
  logic [IW-1:0] touch_idx;

  tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cam (
    .valid(valid_q), .vpn_tab(vpn_q), .asid_tab(asid_q),
    .key_vpn(lk_vpn), .key_asid(lk_asid), .match(lk_match));
  tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_cam (
    .valid(valid_q), .vpn_tab(vpn_q), .asid_tab(asid_q),
    .key_vpn(fill_vpn), .key_asid(fill_asid), .match(fill_match));
  tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_inv_cam (
    .valid(valid_q), .vpn_tab(vpn_q), .asid_tab(asid_q),
    .key_vpn(inv_vpn), .key_asid(inv_asid), .match(inv_match));

  tlb_pick #(.N(N), .IW(IW)) u_lk_enc   (.vec(lk_match),   .any(lk_any),   .idx(lk_idx));
  tlb_pick #(.N(N), .IW(IW)) u_same_enc (.vec(fill_match), .any(same_any), .idx(same_idx));
  tlb_pick #(.N(N), .IW(IW)) u_free_enc (.vec(~valid_q),   .any(free_any), .idx(free_idx));

  tlb_lru #(.N(N), .IW(IW)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx), .victim_idx(lru_idx));

  // lookup, combinational on current contents
  assign lk_hit   = lk_req && lk_any;
  assign lk_pfn   = lk_hit ? pfn_q[lk_idx] : '0;
  assign lk_wr_ok = lk_hit && wr_q[lk_idx];

  // command priority: flush, then invalidate, then fill
  assign do_flush = flush_en;
  assign do_inv   = inv_en && !flush_en;
  assign do_fill  = fill_en && !flush_en && !inv_en;

  always_comb begin
    if (same_any)      src = WAY_SAME;
    else if (free_any) src = WAY_FREE;
    else               src = WAY_LRU;
    unique case (src)
      WAY_SAME: way = same_idx;
      WAY_FREE: way = free_idx;
      default:  way = lru_idx;
    endcase
  end

  assign touch_en  = do_fill || (lk_hit && !flush_en && !inv_en && !fill_en);
  assign touch_idx = do_fill ? way : lk_idx;

  always_ff @(posedge clk) begin
    if (!rst_n)        valid_q <= '0;
    else if (do_flush) valid_q <= '0;
    else if (do_inv)   valid_q <= valid_q & ~inv_match;
    else if (do_fill)  valid_q[way] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      vpn_q[way]  <= fill_vpn;
      asid_q[way] <= fill_asid;
      pfn_q[way]  <= fill_pfn;
      wr_q[way]   <= fill_wr;
    end
  end

  assert_hit_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_req);
  assert_fill_then_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_fill |=> !(lk_req && lk_vpn == $past(fill_vpn) && lk_asid == $past(fill_asid))
                || (lk_hit && lk_pfn == $past(fill_pfn) && lk_wr_ok == $past(fill_wr)));
  assert_keep_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_fill && !(&valid_q)) |=> (($past(valid_q) & ~valid_q) == '0));
  assert_no_duplicate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match) && $onehot0(fill_match));
  assert_inval_gone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_inv |=> !(lk_hit && lk_vpn == $past(inv_vpn) && lk_asid == $past(inv_asid)));
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    do_flush |=> !lk_hit);
endmodule

// File: tb/asid_tlb_tb_top.sv
module asid_tlb_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0, fill_en = 1'b0, inv_en = 1'b0, flush_en = 1'b0, fill_wr = 1'b0;
  logic [19:0] lk_vpn = '0, fill_vpn = '0, inv_vpn = '0, fill_pfn = '0;
  logic [7:0]  lk_asid = '0, fill_asid = '0, inv_asid = '0;
  logic        lk_hit, lk_wr_ok;
  logic [19:0] lk_pfn;

  always #10 clk = ~clk;  // 50 MHz

  asid_tlb dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_wr_ok(lk_wr_ok),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .fill_wr(fill_wr),
    .inv_en(inv_en), .inv_vpn(inv_vpn), .inv_asid(inv_asid), .flush_en(flush_en));

  typedef struct {
    logic        hit;
    logic [19:0] pfn;
    logic        wr;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, fails = 0;

  // reference contents; recency kept as timestamps (smallest = oldest)
  logic        m_v [N];
  logic [19:0] m_vpn [N];
  logic [7:0]  m_asid [N];
  logic [19:0] m_pfn [N];
  logic        m_wr [N];
  int          m_st [N];
  int          m_time = 0;

  function automatic int m_find(input logic [19:0] v, input logic [7:0] a);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v && m_asid[i] == a) return i;
    return -1;
  endfunction

  function automatic int m_way(input logic [19:0] v, input logic [7:0] a);
    int w;
    int best;
    w = m_find(v, a);
    if (w >= 0) return w;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    best = 0;
    for (int i = 1; i < N; i++) if (m_st[i] < m_st[best]) best = i;
    return best;
  endfunction

  // one clock of stimulus; expectation from pre-edge model, then model update
  task automatic cyc(input logic lk, input logic [19:0] lv, input logic [7:0] la,
                     input logic fe, input logic [19:0] fv, input logic [7:0] fa,
                     input logic [19:0] fp, input logic fw,
                     input logic ie, input logic [19:0] iv, input logic [7:0] ia,
                     input logic fl, input string tag);
    exp_t e;
    int h;
    int w;
    @(posedge clk);
    #2;
    lk_req = lk; lk_vpn = lv; lk_asid = la;
    fill_en = fe; fill_vpn = fv; fill_asid = fa; fill_pfn = fp; fill_wr = fw;
    inv_en = ie; inv_vpn = iv; inv_asid = ia; flush_en = fl;
    h = lk ? m_find(lv, la) : -1;
    if (lk) begin
      e.hit = (h >= 0);
      e.pfn = (h >= 0) ? m_pfn[h] : '0;
      e.wr  = (h >= 0) ? m_wr[h] : 1'b0;
      e.tag = tag;
      exp_q.push_back(e);
    end
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    end else if (ie) begin
      for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == iv && m_asid[i] == ia) m_v[i] = 1'b0;
    end else if (fe) begin
      w = m_way(fv, fa);
      m_v[w] = 1'b1; m_vpn[w] = fv; m_asid[w] = fa; m_pfn[w] = fp; m_wr[w] = fw;
      m_time++; m_st[w] = m_time;
    end else if (h >= 0) begin
      m_time++; m_st[h] = m_time;
    end
  endtask

  task automatic look(input logic [19:0] v, input logic [7:0] a, input string tag);
    cyc(1, v, a, 0, '0, '0, '0, 0, 0, '0, '0, 0, tag);
  endtask
  task automatic fill(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p, input logic w);
    cyc(0, '0, '0, 1, v, a, p, w, 0, '0, '0, 0, "");
  endtask
  task automatic inval(input logic [19:0] v, input logic [7:0] a);
    cyc(0, '0, '0, 0, '0, '0, '0, 0, 1, v, a, 0, "");
  endtask
  task automatic idle();
    cyc(0, '0, '0, 0, '0, '0, '0, 0, 0, '0, '0, 0, "");
  endtask

  // monitor: compare mid-cycle, after inputs settled and before the edge
  initial begin
    forever begin
      @(posedge clk);
      #12;
      if (lk_req) begin
        if (exp_q.size() == 0) begin
          fails++; checks++;
          $display("FAIL unexpected lookup result: got hit=%0b, expected no lookup", lk_hit);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          checks++;
          if (lk_hit !== e.hit || (e.hit && (lk_pfn !== e.pfn || lk_wr_ok !== e.wr))) begin
            fails++;
            $display("FAIL %s: got hit=%0b pfn=%h wr=%0b, expected hit=%0b pfn=%h wr=%0b",
                     e.tag, lk_hit, lk_pfn, lk_wr_ok, e.hit, e.pfn, e.wr);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  localparam logic [7:0] A = 8'h11, B = 8'h22;

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 1'b0; m_st[i] = 0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R11 empty after reset
    look(20'h00010, A, "R11");
    look(20'h00100, A, "R11");
    // R3, R1 fill then hit, frame and write bit returned
    for (int i = 0; i < N; i++) begin
      fill(20'h00100 + 20'(i), A, 20'h05000 + 20'(i), i[0]);
      look(20'h00100 + 20'(i), A, "R3");
    end
    for (int i = 0; i < N; i++) look(20'h00100 + 20'(i), A, "R1");
    // R2 identifier mismatch is a plain miss
    look(20'h00100, B, "R2");
    look(20'h00105, 8'h12, "R2");
    // R5 full buffer: refresh one, then new fill evicts the oldest
    look(20'h00103, A, "R5");
    fill(20'h00108, A, 20'h06008, 1'b1);
    for (int i = 0; i < 9; i++) look(20'h00100 + 20'(i), A, "R5");
    fill(20'h00109, A, 20'h06009, 1'b0);
    for (int i = 0; i < 10; i++) look(20'h00100 + 20'(i), A, "R5");
    // R6 refill resident pair in place
    fill(20'h00105, A, 20'hABCDE, 1'b1);
    look(20'h00105, A, "R6");
    for (int i = 0; i < 10; i++) look(20'h00100 + 20'(i), A, "R6");
    // R7 same page under two identifiers, drop only one
    fill(20'h00107, B, 20'h07007, 1'b1);
    look(20'h00107, B, "R7");
    inval(20'h00107, A);
    look(20'h00107, A, "R7");
    look(20'h00107, B, "R7");
    // R4 a free slot exists; fill must not displace a valid entry
    fill(20'h00200, A, 20'h08000, 1'b0);
    look(20'h00200, A, "R4");
    for (int i = 0; i < 10; i++) look(20'h00100 + 20'(i), A, "R4");
    look(20'h00107, B, "R4");
    // R9 switch to B and back
    look(20'h00107, B, "R9");
    look(20'h00105, B, "R9");
    look(20'h00105, A, "R9");
    look(20'h00200, A, "R9");
    // R10 lookup sees contents before same-cycle fill
    cyc(1, 20'h00400, A, 1, 20'h00400, A, 20'h09400, 1'b1, 0, '0, '0, 0, "R10");
    look(20'h00400, A, "R10");
    // R10 lookup sees contents before same-cycle invalidate
    cyc(1, 20'h00400, A, 0, '0, '0, '0, 0, 1, 20'h00400, A, 0, "R10");
    look(20'h00400, A, "R10");
    // R10 invalidate beats fill
    cyc(0, '0, '0, 1, 20'h00500, A, 20'h09500, 1'b0, 1, 20'h00200, A, 0, "");
    look(20'h00500, A, "R10");
    look(20'h00200, A, "R10");
    // R10 flush beats fill; R8 everything gone
    cyc(0, '0, '0, 1, 20'h00600, A, 20'h09600, 1'b0, 0, '0, '0, 1, "");
    look(20'h00600, A, "R10");
    for (int i = 0; i < 10; i++) look(20'h00100 + 20'(i), A, "R8");
    look(20'h00107, B, "R8");
    // refill after flush works
    fill(20'h00700, B, 20'h0A700, 1'b1);
    look(20'h00700, B, "R3");
    idle();
    idle();
    if (exp_q.size() != 0) begin
      fails++; checks++;
      $display("FAIL scoreboard: got %0d pending, expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule